// File: doc/BRIEF.md
# Time-Slot Switch Processor Register Port

This block is the host-side access port of a time-slot switch. A processor reaches it through an asynchronous 8-bit bus. The bus has a chip select (active low), a data strobe (active high), a read/write select and a 6-bit address. The port holds one control register. Through a 32-byte window it also reaches three memories in the switch core: the connection-high memory, the connection-low memory and the data memory. The control register selects the stream whose 32 channels are visible in the window, and it selects the memory behind the window. A split mode sends reads to the data memory and writes to connection-low memory.

Writes to the control register complete at once. Every other access, including a control register read, waits for the core's processor slot, marked by a one-cycle `slot_tick` pulse. At that slot the port issues a single read or write strobe to the core. It pulls the acknowledge line low once the access is done and keeps it low until the processor ends the strobe. The bus controls are synchronised into the system clock. Address and data must be stable while the strobe is high.

Top module: `tsi_cpu_port`

## Requirements
- R1: After synchronous reset, `ack_pull`, `rd_oe`, `mem_rd`, `mem_wr` and `proc_mode` are 0, and the control register reads 0x00.
- R2: An access with address bit 5 at 0 reaches the control register, and address bits 4..0 are ignored. A control register write is acknowledged within SYNC_STAGES+2 cycles of the strobe being applied, whether or not a slot occurs. A read returns the stored value with bit 5 forced to 0.
- R3: A control register read and every windowed access (address bit 5 at 1) are acknowledged only after a `slot_tick`. With slots occurring, the acknowledge arrives within SYNC_STAGES+SLOT+4 cycles.
- R4: A windowed access strobes `mem_addr` = {control bits 2..0, address bits 4..0}. The memory select in control bits 4..3 picks the target: 01 data memory, 10 connection-low, 11 connection-high. `mem_sel` uses the same code.
- R5: When control bit 7 (split) is 1, windowed reads go to the data memory and windowed writes go to connection-low, whatever control bits 4..3 hold.
- R6: Reads from connection-high memory return 0 in data bits 7..3.
- R7: A windowed write that targets the data memory, or the reserved select 00, produces no write strobe and leaves memory unchanged, but it is still acknowledged. A read with select 00 returns 0x00.
- R8: `proc_mode` equals control register bit 6.
- R9: `ack_pull` stays 1 until chip select goes high or the data strobe goes low. It returns to 0 within SYNC_STAGES+2 cycles of that. `rd_oe` is 1 only while a read is being acknowledged.
- R10: `mem_rd` and `mem_wr` are single-cycle pulses, never both at once. Each one comes in the cycle after a `slot_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds | input | 1 | Data strobe, active high, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bit 5 selects control register (0) or window (1); bits 4..0 are the channel |
| wdata | input | 8 | Write data from the processor |
| slot_tick | input | 1 | One-cycle pulse marking the core's processor access slot |
| mem_rdata | input | 8 | Core read data, valid the cycle after `mem_rd` |
| ack_pull | output | 1 | 1 = pull the open-drain acknowledge line low |
| rd_data | output | 8 | Read data toward the processor |
| rd_oe | output | 1 | Drive enable for `rd_data` |
| mem_rd | output | 1 | Core memory read strobe |
| mem_wr | output | 1 | Core memory write strobe |
| mem_sel | output | 2 | Target memory: 01 data, 10 connection-low, 11 connection-high |
| mem_addr | output | 8 | {stream, channel} memory address |
| mem_wdata | output | 8 | Core memory write data |
| proc_mode | output | 1 | Global processor-mode flag (control bit 6) |

## Verification
The hardest state to reach from the ports is an access parked waiting for a slot. The port can only show this as an acknowledge that has not yet arrived, which looks the same as a slow slot. The bench turns its slot generator off, starts a control register read, checks that no acknowledge appears over a long interval, and then turns slots back on and measures the remaining latency. Random accesses mix split mode, every memory select including the reserved one, and random streams and channels. They are checked against a shadow copy of the three memories kept from the requirements.

// File: rtl/tsi_port_pkg.sv
package tsi_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STRB,
    ST_LOAD,
    ST_ACK
  } seq_state_e;

  // control register bit positions (neighbours decode these)
  localparam int CTL_SPLIT  = 7;
  localparam int CTL_PMODE  = 6;
  localparam int CTL_MSEL_H = 4;
  localparam int CTL_MSEL_L = 3;

  // memory reached by a windowed access
  function automatic mem_sel_e pick_target(input logic is_read,
                                           input logic split,
                                           input logic [1:0] msel);
    if (split) return is_read ? SEL_DATA : SEL_CML;
    return mem_sel_e'(msel);
  endfunction

endpackage

// File: rtl/tsi_sync.sv
module tsi_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RESET_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RESET_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg #(
  parameter int STREAM_W = 3,
  localparam int VAL_W = STREAM_W + 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_split,
  input  logic                wr_pmode,
  input  logic [1:0]          wr_msel,
  input  logic [STREAM_W-1:0] wr_strm,
  output logic                split,
  output logic                pmode,
  output logic [1:0]          msel,
  output logic [STREAM_W-1:0] strm,
  output logic [VAL_W-1:0]    value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      split <= 1'b0;
      pmode <= 1'b0;
      msel  <= 2'b00;
      strm  <= '0;
    end else if (wr_en) begin
      split <= wr_split;
      pmode <= wr_pmode;
      msel  <= wr_msel;
      strm  <= wr_strm;
    end
  end

  // spare bit reads back as zero
  assign value = {split, pmode, 1'b0, msel, strm};

endmodule

// File: rtl/tsi_access_seq.sv
module tsi_access_seq
  import tsi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 5,
  parameter int STREAM_W = 3,
  parameter int CMH_BITS = 3,
  localparam int ADDR_W = CHAN_W + 1,
  localparam int MEM_AW = STREAM_W + CHAN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act,
  input  logic                rw_in,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [DATA_W-1:0]   wdata_in,
  input  logic                slot_tick,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                split,
  input  logic [1:0]          msel,
  input  logic [STREAM_W-1:0] strm,
  input  logic [DATA_W-1:0]   ctrl_value,
  output logic                ctrl_wr,
  output logic                ack_pull,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_oe,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [1:0]          mem_sel,
  output logic [MEM_AW-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);

  localparam logic [DATA_W-1:0] CMH_MASK = DATA_W'((1 << CMH_BITS) - 1);

  seq_state_e        state;
  logic              lat_rw;
  logic              lat_reg;
  logic [CHAN_W-1:0] lat_chan;
  logic [DATA_W-1:0] lat_wdata;
  mem_sel_e          tgt;
  logic              rd_ok;
  logic              wr_ok;

  always_comb begin
    tgt     = pick_target(lat_rw, split, msel);
    rd_ok   = lat_rw && (tgt != SEL_NONE);
    wr_ok   = !lat_rw && ((tgt == SEL_CML) || (tgt == SEL_CMH));
    ctrl_wr = (state == ST_IDLE) && act && !rw_in && !addr_in[ADDR_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lat_rw    <= 1'b0;
      lat_reg   <= 1'b0;
      lat_chan  <= '0;
      lat_wdata <= '0;
      ack_pull  <= 1'b0;
      rd_data   <= '0;
      rd_oe     <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_sel   <= SEL_NONE;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (act) begin
            lat_rw    <= rw_in;
            lat_reg   <= !addr_in[ADDR_W-1];
            lat_chan  <= addr_in[CHAN_W-1:0];
            lat_wdata <= wdata_in;
            if (ctrl_wr) begin
              ack_pull <= 1'b1;
              state    <= ST_ACK;
            end else begin
              state    <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (slot_tick) begin
            if (lat_reg) begin
              rd_data  <= ctrl_value;
              rd_oe    <= 1'b1;
              ack_pull <= 1'b1;
              state    <= ST_ACK;
            end else begin
              mem_rd    <= rd_ok;
              mem_wr    <= wr_ok;
              mem_sel   <= tgt;
              mem_addr  <= {strm, lat_chan};
              mem_wdata <= lat_wdata;
              state     <= ST_STRB;
            end
          end
        end
        ST_STRB: begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!rd_ok)               rd_data <= '0;
          else if (tgt == SEL_CMH)  rd_data <= mem_rdata & CMH_MASK;
          else                      rd_data <= mem_rdata;
          rd_oe    <= lat_rw;
          ack_pull <= 1'b1;
          state    <= ST_ACK;
        end
        ST_ACK: begin
          if (!act) begin
            ack_pull <= 1'b0;
            rd_oe    <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
  import tsi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CHAN_W = 5,
  parameter int STREAM_W = 3,
  parameter int CMH_BITS = 3,
  localparam int DATA_W = STREAM_W + 5,
  localparam int ADDR_W = CHAN_W + 1,
  localparam int MEM_AW = STREAM_W + CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ds,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              slot_tick,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ack_pull,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [1:0]        mem_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              proc_mode
);

  logic [1:0]          bus_s;
  logic                act;
  logic                ctrl_wr;
  logic                split;
  logic [1:0]          msel;
  logic [STREAM_W-1:0] strm;
  logic [DATA_W-1:0]   ctrl_value;

  tsi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, ds}),
    .q   (bus_s)
  );

  assign act = !bus_s[1] && bus_s[0];

  tsi_ctrl_reg #(.STREAM_W(STREAM_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_wr),
    .wr_split (wdata[CTL_SPLIT]),
    .wr_pmode (wdata[CTL_PMODE]),
    .wr_msel  (wdata[CTL_MSEL_H:CTL_MSEL_L]),
    .wr_strm  (wdata[STREAM_W-1:0]),
    .split    (split),
    .pmode    (proc_mode),
    .msel     (msel),
    .strm     (strm),
    .value    (ctrl_value)
  );

  tsi_access_seq #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .STREAM_W(STREAM_W), .CMH_BITS(CMH_BITS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .rw_in      (rw),
    .addr_in    (addr),
    .wdata_in   (wdata),
    .slot_tick  (slot_tick),
    .mem_rdata  (mem_rdata),
    .split      (split),
    .msel       (msel),
    .strm       (strm),
    .ctrl_value (ctrl_value),
    .ctrl_wr    (ctrl_wr),
    .ack_pull   (ack_pull),
    .rd_data    (rd_data),
    .rd_oe      (rd_oe),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_sel    (mem_sel),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

endmodule

// File: rtl/tsi_cpu_port_chk.sv
module tsi_cpu_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       act,
  input logic       slot_tick,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [1:0] mem_sel,
  input logic       ack_pull,
  input logic       rd_oe
);

  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_quiet_R1: assert (!ack_pull && !rd_oe && !mem_rd && !mem_wr)
        else $error("outputs active right after reset");
    end
    rst_q <= rst;
  end

  assert_strobe_after_slot_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> $past(slot_tick));

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));

  assert_no_data_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_sel == 2'b10 || mem_sel == 2'b11));

  assert_data_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> ack_pull);

  assert_ack_held_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_pull) |-> $past(!act));

endmodule

bind tsi_cpu_port tsi_cpu_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .act       (act),
  .slot_tick (slot_tick),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_sel   (mem_sel),
  .ack_pull  (ack_pull),
  .rd_oe     (rd_oe)
);

// File: tb/tsi_cpu_port_test.sv
module tsi_cpu_port_test;

  localparam int SYNC = 2;
  localparam int SLOT = 16;
  localparam int FAST_LIM = SYNC + 2;
  localparam int MEM_LIM = SYNC + SLOT + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       ds = 1'b0;
  logic       rw = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       slot_tick = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic       ack_pull, rd_oe, mem_rd, mem_wr, proc_mode;
  logic [7:0] rd_data, mem_addr, mem_wdata;
  logic [1:0] mem_sel;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int wr_count = 0;
  int slot_cnt = 0;
  logic slots_on = 1'b1;
  logic [7:0] mdl [0:767];
  logic [7:0] shadow [0:767];

  always #5 clk = ~clk;

  tsi_cpu_port #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
    .wdata(wdata), .slot_tick(slot_tick), .mem_rdata(mem_rdata),
    .ack_pull(ack_pull), .rd_data(rd_data), .rd_oe(rd_oe), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .proc_mode(proc_mode)
  );

  function automatic int midx(input logic [1:0] sel, input logic [7:0] a);
    return (sel == 2'b00) ? 0 : (int'(sel) - 1) * 256 + int'(a);
  endfunction

  // core memory stand-in, one-cycle read latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    slot_cnt <= (slot_cnt == SLOT - 1) ? 0 : slot_cnt + 1;
    if (!rst && mem_rd) mem_rdata <= mdl[midx(mem_sel, mem_addr)];
    if (!rst && mem_wr) begin
      wr_count <= wr_count + 1;
      mdl[midx(mem_sel, mem_addr)] <= mem_wdata;
    end
  end

  always @(negedge clk) slot_tick <= slots_on && (slot_cnt == SLOT - 1);

  task automatic chk(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic start_acc(input logic rd, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    rw = rd; addr = a; wdata = d; cs_n = 1'b0; ds = 1'b1;
  endtask

  task automatic wait_ack(input int limit, output int n);
    n = 0;
    while (!ack_pull && n < limit + 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic end_acc(output int n);
    @(negedge clk);
    cs_n = 1'b1; ds = 1'b0;
    n = 0;
    while (ack_pull && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic access(input string req, input logic rd, input logic [5:0] a,
                        input logic [7:0] d, input int limit, output logic [7:0] q);
    int n, m;
    start_acc(rd, a, d);
    wait_ack(limit, n);
    chk({req, " ack latency"}, int'(n <= limit), 1);
    chk({req, " rd_oe R9"}, int'(rd_oe), int'(rd));
    q = rd_data;
    end_acc(m);
    chk({req, " ack release R9"}, int'(m <= SYNC + 2), 1);
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    logic [7:0] q;
    access("R2 ctrl write", 1'b0, 6'h00, v, FAST_LIM, q);
  endtask

  function automatic logic [1:0] tgt_of(input logic rd, input logic [7:0] c);
    if (c[7]) return rd ? 2'b01 : 2'b10;
    return c[4:3];
  endfunction

  initial begin
    logic [7:0] q;
    logic [7:0] c;
    int n, m, w0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 768; i++) begin
      mdl[i] = (i < 256) ? 8'(i * 7 + 3) : 8'h00;
      shadow[i] = mdl[i];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack_pull", int'(ack_pull), 0);
    chk("R1 rd_oe", int'(rd_oe), 0);
    chk("R1 strobes", int'(mem_rd | mem_wr), 0);
    chk("R1 proc_mode", int'(proc_mode), 0);
    access("R1 ctrl read", 1'b1, 6'h00, 8'h00, MEM_LIM, q);
    chk("R1 ctrl value", int'(q), 0);

    // R2 fast ctrl write with slots stopped; other address bits ignored
    slots_on = 1'b0;
    access("R2 fast write", 1'b0, 6'h1F, 8'h6A, FAST_LIM, q);
    chk("R8 proc_mode set", int'(proc_mode), 1);
    // R3 ctrl read parks until a slot
    start_acc(1'b1, 6'h05, 8'h00);
    repeat (60) @(negedge clk);
    chk("R3 no ack without slot", int'(ack_pull), 0);
    slots_on = 1'b1;
    wait_ack(SLOT + 4, n);
    chk("R3 ack after slot", int'(n <= SLOT + 4), 1);
    chk("R2 readback bit5 zero", int'(rd_data), 8'h4A);
    end_acc(m);

    // R4 window addressing, connection-low, stream 5
    set_ctrl(8'h15);
    chk("R8 proc_mode clear", int'(proc_mode), 0);
    w0 = wr_count;
    access("R4 cml write", 1'b0, 6'h27, 8'hA5, MEM_LIM, q);
    chk("R4 one strobe", wr_count - w0, 1);
    chk("R4 mem_addr", int'(mem_addr), 8'hA7);
    chk("R4 mem_sel", int'(mem_sel), 2);
    shadow[midx(2'b10, 8'hA7)] = 8'hA5;
    access("R4 cml read", 1'b1, 6'h27, 8'h00, MEM_LIM, q);
    chk("R4 cml data", int'(q), 8'hA5);

    // R6 connection-high masking
    set_ctrl(8'h1D);
    access("R6 cmh write", 1'b0, 6'h27, 8'hFF, MEM_LIM, q);
    shadow[midx(2'b11, 8'hA7)] = 8'hFF;
    access("R6 cmh read", 1'b1, 6'h27, 8'h00, MEM_LIM, q);
    chk("R6 cmh upper zero", int'(q), 8'h07);

    // R7 data memory write ignored, reserved select
    set_ctrl(8'h0B);
    w0 = wr_count;
    access("R7 data write", 1'b0, 6'h24, 8'h99, MEM_LIM, q);
    chk("R7 no strobe data", wr_count - w0, 0);
    access("R4 data read", 1'b1, 6'h24, 8'h00, MEM_LIM, q);
    chk("R7 data unchanged", int'(q), int'(shadow[8'h64]));
    set_ctrl(8'h03);
    w0 = wr_count;
    access("R7 reserved write", 1'b0, 6'h21, 8'h55, MEM_LIM, q);
    chk("R7 no strobe reserved", wr_count - w0, 0);
    access("R7 reserved read", 1'b1, 6'h21, 8'h00, MEM_LIM, q);
    chk("R7 reserved reads zero", int'(q), 0);

    // R5 split mode with select pointing at connection-high
    set_ctrl(8'h9A);
    access("R5 split write", 1'b0, 6'h23, 8'h3C, MEM_LIM, q);
    shadow[midx(2'b10, 8'h43)] = 8'h3C;
    chk("R5 write went to cml", int'(mem_sel), 2);
    access("R5 split read", 1'b1, 6'h23, 8'h00, MEM_LIM, q);
    chk("R5 read from data", int'(q), int'(shadow[8'h43]));
    set_ctrl(8'h12);
    access("R5 cml check", 1'b1, 6'h23, 8'h00, MEM_LIM, q);
    chk("R5 cml holds split write", int'(q), 8'h3C);

    // R9 acknowledge held while strobe stays high
    start_acc(1'b1, 6'h23, 8'h00);
    wait_ack(MEM_LIM, n);
    repeat (12) @(negedge clk);
    chk("R9 ack held", int'(ack_pull), 1);
    chk("R9 rd_oe held", int'(rd_oe), 1);
    end_acc(m);
    chk("R9 ack released", int'(ack_pull), 0);

    // random mix against shadow
    for (int k = 0; k < 80; k++) begin
      logic rd;
      logic [4:0] ch;
      logic [7:0] d, e;
      logic [1:0] t;
      int ix;
      c = 8'($urandom);
      c[7] = ($urandom % 4) == 0;
      set_ctrl(c);
      chk("R8 proc_mode random", int'(proc_mode), int'(c[6]));
      rd = 1'($urandom);
      ch = 5'($urandom);
      d = 8'($urandom);
      t = tgt_of(rd, c);
      ix = midx(t, {c[2:0], ch});
      w0 = wr_count;
      access("R4 random", rd, {1'b1, ch}, d, MEM_LIM, q);
      if (rd) begin
        if (t == 2'b00) e = 8'h00;
        else if (t == 2'b11) e = shadow[ix] & 8'h07;
        else e = shadow[ix];
        chk(c[7] ? "R5 random read" : "R6 random read", int'(q), int'(e));
      end else begin
        if (t == 2'b10 || t == 2'b11) begin
          shadow[ix] = d;
          chk("R4 random write strobe", wr_count - w0, 1);
        end else begin
          chk("R7 random ignored write", wr_count - w0, 0);
        end
      end
    end
    for (int i = 256; i < 768; i++) chk("R4 memory contents", int'(mdl[i]), int'(shadow[i]));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule